// File: doc/BRIEF.md
# Guarded Packet Frame Generator

This block emits a repeating byte stream for a single data lane of a time-slotted optical link. Every slot carries one frame with three parts. It opens with a dark guard interval made of zero bytes. A run of alternating-bit bytes follows so that the receiver's clock recovery can lock. The frame ends with a payload taken from the start of a 2^13-1 pseudo-random bit sequence. With the default sizes the frame is 640 bytes, which is a multiple of 32. That is a 0.512 µs slot at 10 Gb/s, and the payload fills about 85% of it.

A run control starts the frame train and stops it. A stop lets the current frame finish, and the lane goes dark afterwards. A per-frame enable is sampled once at each frame boundary. A disabled frame still takes up its full slot, but every byte of it is zero. The outputs are registered and byte-wide. A valid flag, a frame-start marker and a payload-start marker go with them, so that a downstream serializer or test harness can align to the frame.

Top module: `pkt_frame_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `valid_o`, `data_o`, `frame_start_o` and `pay_start_o` are all zero.
- R2: While no frame is in progress, `valid_o` is 0, `data_o` is 0x00 and both markers are 0.
- R3: When `run_i` is first sampled high while idle, the first frame byte appears two clock edges later. Frame bytes 0..63 are 0x00, and `frame_start_o` is 1 on byte 0 and on no other byte.
- R4: In an enabled frame, bytes 64..93 are 0xAA.
- R5: In an enabled frame, bytes 94..639 are the PRBS payload, and `pay_start_o` is 1 on byte 94 only. The PRBS register is 13 bits and starts from all ones. Each step outputs bit 12 and shifts left, and bit 0 receives the XOR of bits 12, 11, 1 and 0 (polynomial x^13+x^12+x^2+x+1). Each payload byte packs 8 successive output bits with the first one in bit 7.
- R6: The PRBS restarts from its seed at every payload, so every enabled frame carries the same 546 payload bytes.
- R7: A frame is exactly 640 bytes and `valid_o` stays 1 for all of them. While `run_i` stays high, the next frame's byte 0 follows byte 639 on the very next cycle.
- R8: If `run_i` is deasserted partway through a frame, that frame still completes all 640 bytes. After it, `valid_o` stays 0.
- R9: `frame_en_i` is sampled at the edge that starts a frame. If it is 0, that frame keeps `valid_o` at 1 and `frame_start_o` on byte 0, but all 640 data bytes are 0x00 and `pay_start_o` stays 0.
- R10: A change of `frame_en_i` partway through a frame has no effect on that frame's bytes or markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start the frame train while high; a low value ends it at the next frame boundary |
| frame_en_i | input | 1 | Enable for the frame that starts next; 0 makes that frame dark |
| data_o | output | 8 | Output byte |
| valid_o | output | 1 | High for every byte of a frame, including dark bytes |
| frame_start_o | output | 1 | High on the first guard byte of each frame |
| pay_start_o | output | 1 | High on the first payload byte of an enabled frame |

## Verification
The assertions assume that `run_i` and `frame_en_i` are stable around each rising edge. They also assume that reset is held for at least one edge before the first frame. The bench meets both by changing the controls only on falling edges, after sampling the outputs. Outside reset it toggles the controls only at chosen byte indices inside a frame, so frame boundaries, mid-frame enable changes and a stop partway through a frame are each reached on purpose.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    SEG_GUARD = 2'd0,
    SEG_PRE   = 2'd1,
    SEG_PAY   = 2'd2
  } seg_e;

  // position summary handed from the sequencer to the datapath
  typedef struct packed {
    logic active;
    logic en;
    seg_e seg;
    logic first;
  } seq_t;

endpackage

// File: rtl/pfg_seq.sv
module pfg_seq
  import pfg_pkg::*;
#(
  parameter int GUARD_LEN = 64,
  parameter int PRE_LEN   = 30,
  parameter int PAY_LEN   = 546
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic frame_en_i,
  output seq_t pos_o
);

  localparam int FRAME_LEN = GUARD_LEN + PRE_LEN + PAY_LEN;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(GUARD_LEN - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(PAY_LEN - 1);

  logic             active_q;
  logic             en_q;
  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seg_last;

  always_comb begin
    case (seg_q)
      SEG_GUARD: seg_last = (cnt_q == G_LAST);
      SEG_PRE:   seg_last = (cnt_q == P_LAST);
      SEG_PAY:   seg_last = (cnt_q == D_LAST);
      default:   seg_last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      en_q     <= 1'b0;
      seg_q    <= SEG_GUARD;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (run_i) begin
        active_q <= 1'b1;
        en_q     <= frame_en_i;
        seg_q    <= SEG_GUARD;
        cnt_q    <= '0;
      end
    end else if (seg_last) begin
      cnt_q <= '0;
      case (seg_q)
        SEG_GUARD: seg_q <= SEG_PRE;
        SEG_PRE:   seg_q <= SEG_PAY;
        default: begin
          seg_q <= SEG_GUARD;
          if (run_i) begin
            en_q <= frame_en_i;
          end else begin
            active_q <= 1'b0;
          end
        end
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    pos_o.active = active_q;
    pos_o.en     = en_q;
    pos_o.seg    = seg_q;
    pos_o.first  = (cnt_q == '0);
  end

endmodule

// File: rtl/pfg_prbs.sv
module pfg_prbs #(
  parameter int          LFSR_W = 13,
  parameter int          BYTE_W = 8,
  parameter logic [31:0] TAPS   = 32'h0000_1803,
  parameter logic [31:0] SEED   = 32'h0000_1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  output logic [BYTE_W-1:0] byte_o
);

  localparam logic [LFSR_W-1:0] TAP_MASK  = TAPS[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] SEED_VAL  = SEED[LFSR_W-1:0];

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] chain [BYTE_W+1];

  assign chain[0] = state_q;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_step
    assign byte_o[BYTE_W-1-b] = chain[b][LFSR_W-1];
    assign chain[b+1] = {chain[b][LFSR_W-2:0], ^(chain[b] & TAP_MASK)};
  end

  // reseeded whenever no payload byte is being produced
  always_ff @(posedge clk) begin
    if (rst || !step_i) begin
      state_q <= SEED_VAL;
    end else begin
      state_q <= chain[BYTE_W];
    end
  end

endmodule

// File: rtl/pfg_out.sv
module pfg_out
  import pfg_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  PRE_BYTE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_t              pos_i,
  input  logic [BYTE_W-1:0] prbs_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_start_o,
  output logic              pay_start_o
);

  logic [BYTE_W-1:0] byte_d;
  logic              lit;

  assign lit = pos_i.active && pos_i.en;

  always_comb begin
    byte_d = '0;
    if (lit) begin
      case (pos_i.seg)
        SEG_PRE: byte_d = BYTE_W'(PRE_BYTE);
        SEG_PAY: byte_d = prbs_i;
        default: byte_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o        <= '0;
      valid_o       <= 1'b0;
      frame_start_o <= 1'b0;
      pay_start_o   <= 1'b0;
    end else begin
      data_o        <= byte_d;
      valid_o       <= pos_i.active;
      frame_start_o <= pos_i.active && pos_i.seg == SEG_GUARD && pos_i.first;
      pay_start_o   <= lit && pos_i.seg == SEG_PAY && pos_i.first;
    end
  end

endmodule

// File: rtl/pkt_frame_gen.sv
module pkt_frame_gen
  import pfg_pkg::*;
#(
  parameter int          GUARD_LEN = 64,
  parameter int          PRE_LEN   = 30,
  parameter int          PAY_LEN   = 546,
  parameter logic [7:0]  PRE_BYTE  = 8'hAA,
  parameter logic [31:0] PRBS_SEED = 32'h0000_1FFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       frame_en_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       frame_start_o,
  output logic       pay_start_o
);

  localparam int BYTE_W = 8;

  seq_t              pos;
  logic [BYTE_W-1:0] prbs_byte;
  logic              in_pay;

  assign in_pay = pos.active && pos.seg == SEG_PAY;

  pfg_seq #(
    .GUARD_LEN (GUARD_LEN),
    .PRE_LEN   (PRE_LEN),
    .PAY_LEN   (PAY_LEN)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .frame_en_i (frame_en_i),
    .pos_o      (pos)
  );

  pfg_prbs #(
    .LFSR_W (13),
    .BYTE_W (BYTE_W),
    .TAPS   (32'h0000_1803),
    .SEED   (PRBS_SEED)
  ) i_prbs (
    .clk    (clk),
    .rst    (rst),
    .step_i (in_pay),
    .byte_o (prbs_byte)
  );

  pfg_out #(
    .BYTE_W   (BYTE_W),
    .PRE_BYTE (PRE_BYTE)
  ) i_out (
    .clk           (clk),
    .rst           (rst),
    .pos_i         (pos),
    .prbs_i        (prbs_byte),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .frame_start_o (frame_start_o),
    .pay_start_o   (pay_start_o)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int         GUARD_LEN = 64,
  parameter int         PRE_LEN   = 30,
  parameter int         PAY_LEN   = 546,
  parameter logic [7:0] PRE_BYTE  = 8'hAA
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       frame_start_o,
  input logic       pay_start_o
);

  localparam int FRAME_LEN = GUARD_LEN + PRE_LEN + PAY_LEN;

  // index of the byte on the outputs when not a frame start; byte count of the last frame otherwise
  int unsigned seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 0;
    end else if (frame_start_o) begin
      seen_q <= 1;
    end else if (valid_o) begin
      seen_q <= seen_q + 1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!valid_o && data_o == 8'h00)); // R1
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (data_o == 8'h00 && !frame_start_o && !pay_start_o)); // R2
  AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (frame_start_o || seen_q < GUARD_LEN)) |-> data_o == 8'h00); // R3
  AST_PRE_BEFORE_PAY: assert property (@(posedge clk) disable iff (rst)
    pay_start_o |-> $past(data_o) == PRE_BYTE); // R4
  AST_PAY_POSITION: assert property (@(posedge clk) disable iff (rst)
    pay_start_o |-> (valid_o && !frame_start_o && seen_q == GUARD_LEN + PRE_LEN)); // R5
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && seen_q != 0) |-> seen_q == FRAME_LEN); // R7
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_o) |-> seen_q == FRAME_LEN); // R8

endmodule

bind pkt_frame_gen pfg_checker #(
  .GUARD_LEN (GUARD_LEN),
  .PRE_LEN   (PRE_LEN),
  .PAY_LEN   (PAY_LEN),
  .PRE_BYTE  (PRE_BYTE)
) i_pfg_checker (
  .clk           (clk),
  .rst           (rst),
  .data_o        (data_o),
  .valid_o       (valid_o),
  .frame_start_o (frame_start_o),
  .pay_start_o   (pay_start_o)
);

// File: tb/test_pkt_frame_gen.sv
module test_pkt_frame_gen;

  localparam int CLK_PERIOD = 10;
  localparam int GL = 64;
  localparam int PL = 30;
  localparam int DL = 546;
  localparam int FL = GL + PL + DL;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_i = 1'b0;
  logic       frame_en_i = 1'b1;
  logic [7:0] data_o;
  logic       valid_o;
  logic       frame_start_o;
  logic       pay_start_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_pay [DL];
  logic [7:0] cap_d [FL];
  logic       cap_v [FL];
  logic       cap_fs [FL];
  logic       cap_ps [FL];
  int         gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_frame_gen i_pkt_frame_gen (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run_i),
    .frame_en_i    (frame_en_i),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .frame_start_o (frame_start_o),
    .pay_start_o   (pay_start_o)
  );

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic build_expected();
    logic [12:0] s = 13'h1FFF;
    for (int i = 0; i < DL; i++) begin
      logic [7:0] b = '0;
      for (int k = 0; k < 8; k++) begin
        logic bit_out = s[12];
        logic fb = s[12] ^ s[11] ^ s[1] ^ s[0];
        s = {s[11:0], fb};
        b = {b[6:0], bit_out};
      end
      exp_pay[i] = b;
    end
  endtask

  task automatic wait_start();
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!frame_start_o && gap < 3000);
  endtask

  // act_at < 0: no action; otherwise drive enable/run right after sampling that byte
  task automatic capture(input int act_at, input bit set_en, input logic en_v,
                         input bit set_run, input logic run_v);
    for (int i = 0; i < FL; i++) begin
      if (i > 0) @(negedge clk);
      cap_d[i]  = data_o;
      cap_v[i]  = valid_o;
      cap_fs[i] = frame_start_o;
      cap_ps[i] = pay_start_o;
      if (i == act_at) begin
        if (set_en) frame_en_i = en_v;
        if (set_run) run_i = run_v;
      end
    end
  endtask

  task automatic check_frame(input bit en, input string rq);
    int bad_g = 0, bad_p = 0, bad_d = 0, bad_v = 0, bad_fs = 0, bad_ps = 0, first_bad = -1;
    for (int i = 0; i < FL; i++) begin
      logic [7:0] e;
      if (i < GL) e = 8'h00;
      else if (i < GL + PL) e = en ? 8'hAA : 8'h00;
      else e = en ? exp_pay[i-GL-PL] : 8'h00;
      if (cap_d[i] !== e) begin
        if (first_bad < 0) first_bad = i;
        if (i < GL) bad_g++; else if (i < GL + PL) bad_p++; else bad_d++;
      end
      if (cap_v[i] !== 1'b1) bad_v++;
      if (cap_fs[i] !== (i == 0)) bad_fs++;
      if (cap_ps[i] !== (en && i == GL + PL)) bad_ps++;
    end
    check(bad_g == 0, {rq, "/R3"}, "guard bytes wrong", bad_g, 0);
    check(bad_fs == 0, {rq, "/R3"}, "frame_start placement errors", bad_fs, 0);
    check(bad_p == 0, en ? {rq, "/R4"} : {rq, "/R9"}, "preamble bytes wrong", bad_p, 0);
    check(bad_d == 0, en ? {rq, "/R5"} : {rq, "/R9"}, "payload bytes wrong", bad_d, 0);
    check(bad_ps == 0, en ? {rq, "/R5"} : {rq, "/R9"}, "pay_start placement errors", bad_ps, 0);
    check(bad_v == 0, {rq, "/R7"}, "valid low inside frame", bad_v, 0);
    if (first_bad >= 0) $display("  first mismatching byte index %0d", first_bad);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(valid_o === 1'b0 && data_o === 8'h00 && frame_start_o === 1'b0 && pay_start_o === 1'b0,
          "R1", "outputs during reset", {valid_o, frame_start_o, pay_start_o, data_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b0 && data_o === 8'h00, "R1", "outputs after reset", {valid_o, data_o}, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (valid_o !== 1'b0 || data_o !== 8'h00 || frame_start_o !== 1'b0 || pay_start_o !== 1'b0) bad++;
    end
    check(bad == 0, "R2", "idle cycles not dark", bad, 0);
  endtask

  task automatic t_first_frame();
    run_i = 1'b1;
    frame_en_i = 1'b1;
    wait_start();
    check(gap == 2, "R3", "edges from run to first byte", gap, 2);
    capture(-1, 0, 1'b0, 0, 1'b0);
    check_frame(1'b1, "R5");
  endtask

  task automatic t_back_to_back_then_disable();
    wait_start();
    check(gap == 1, "R7", "cycles between frames", gap, 1);
    capture(300, 1, 1'b0, 0, 1'b0);
    check_frame(1'b1, "R10");
    check_frame(1'b1, "R6");
  endtask

  task automatic t_dark_frame();
    wait_start();
    check(gap == 1, "R9", "dark frame slot follows", gap, 1);
    capture(200, 1, 1'b1, 0, 1'b0);
    check_frame(1'b0, "R10");
  endtask

  task automatic t_stop_mid_frame();
    int bad = 0;
    wait_start();
    check(gap == 1, "R7", "re-enabled frame follows", gap, 1);
    capture(100, 0, 1'b0, 1, 1'b0);
    check_frame(1'b1, "R8");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (valid_o !== 1'b0 || data_o !== 8'h00 || frame_start_o !== 1'b0) bad++;
    end
    check(bad == 0, "R8", "activity after stop", bad, 0);
  endtask

  task automatic t_restart();
    run_i = 1'b1;
    wait_start();
    check(gap == 2, "R3", "edges from restart to first byte", gap, 2);
    capture(-1, 0, 1'b0, 0, 1'b0);
    check_frame(1'b1, "R6");
    run_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    build_expected();
    t_reset();
    t_idle();
    t_first_frame();
    t_back_to_back_then_disable();
    t_dark_frame();
    t_stop_mid_frame();
    t_restart();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule